// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit sits beside an I2C controller core and turns the core's one-cycle event pulses into sticky status flags. Seven event classes are tracked: arbitration lost, NACK received, access ready, receive data ready, transmit data ready, stop condition seen, and addressed as a slave. Software selects which of them may interrupt through a 16-bit enable mask. A single interrupt line goes high while any enabled flag is pending.

Software services the unit by reading a vector register in a loop. Each read returns a small code naming the most urgent pending enabled event, and retires that event unless it is one of the two data events. Those two are retired as a side effect of the data path: the receive flag when the receive data register is read, the transmit flag when the transmit data register is written. The data path strobes two inputs to report this. Any flag may also be cleared by writing a one to its status bit. The status register also shows two live core conditions: receive shift register full and bus busy.

Top module: `i2c_irq_unit`

## Requirements
- R1: A pulse on event input bit i sets status flag i on the next clock edge. Bit positions are 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected and 6 addressed as slave. The same positions apply in the mask and in status bits 6:0.
- R2: The mask register sits at byte offset 0x04. It stores and reads back all 16 bits written to it.
- R3: The vector register sits at byte offset 0x28. It returns in bits 2:0 the code of the selected event: arbitration lost 1, NACK 2, access ready 3, receive 4, transmit 5, stop 6, addressed as slave 7. It returns 0 when no enabled flag is pending. Bits 15:3 read as zero.
- R4: When several enabled flags are pending, the vector reports the one with the lowest code.
- R5: A flag whose mask bit is 0 stays visible in the status register but adds nothing to the vector or the interrupt.
- R6: The irq output is high exactly when some status flag and its mask bit are both 1.
- R7: The status register sits at byte offset 0x08. Writing 1 to any of bits 6:0 clears that flag, and writing 0 leaves it as it is.
- R8: A read of the vector register clears the reported flag for codes 1, 2, 3, 6 and 7. It leaves the flag set for codes 4 and 5, so repeated reads walk through the pending events.
- R9: A pulse on rx_data_rd clears the receive-ready flag. A pulse on tx_data_wr clears the transmit-ready flag.
- R10: An event pulse arriving in the same cycle as any clear of the same flag leaves the flag set.
- R11: After reset, all flags are 0, the mask is 0, the vector reads 0 and irq is low.
- R12: Status bit 11 shows rs_full and bit 12 shows bus_busy, both live. Writes to the vector offset or to unmapped offsets change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 7 | One-cycle event pulses from the core, bit order as in R1 |
| rs_full | input | 1 | Live receive shift register full condition |
| bus_busy | input | 1 | Live bus busy condition |
| rx_data_rd | input | 1 | Strobe: receive data register was read |
| tx_data_wr | input | 1 | Strobe: transmit data register was written |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only on the vector) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
A new event pulse can land in the same cycle as a clear of the same flag. The clear may be a write-one to the status register or a vector read that retires the flag. The bench provokes both collisions. It raises the event and the access on the same falling edge, so both are sampled at one rising edge. It then judges the result by reading status and vector afterwards: the flag must still be set and the vector must still name it.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NUM_EV  = 7;
    localparam int CODE_W  = 3;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h28;

    localparam int STAT_RSFULL_BIT = 11;
    localparam int STAT_BUSY_BIT   = 12;

    localparam int EV_RX_IDX = 3;
    localparam int EV_TX_IDX = 4;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    typedef enum logic [CODE_W-1:0] {
        VEC_NONE = 3'd0,
        VEC_ARB  = 3'd1,
        VEC_NACK = 3'd2,
        VEC_ARDY = 3'd3,
        VEC_RX   = 3'd4,
        VEC_TX   = 3'd5,
        VEC_STOP = 3'd6,
        VEC_AAS  = 3'd7
    } vec_code_e;

    typedef enum logic [1:0] {
        SEL_MASK,
        SEL_STAT,
        SEL_VEC,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [REG_W-1:0]  wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_MASK: return SEL_MASK;
            OFS_STAT: return SEL_STAT;
            OFS_VEC:  return SEL_VEC;
            default:  return SEL_NONE;
        endcase
    endfunction

    // Codes whose flag a vector read retires; data events wait for the data path.
    function automatic logic retire_on_read(input vec_code_e c);
        return (c != VEC_NONE) && (c != VEC_RX) && (c != VEC_TX);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import i2c_irq_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_o[i] <= 1'b0;
            else if (set_i[i])
                flag_o[i] <= 1'b1;
            else if (clr_i[i])
                flag_o[i] <= 1'b0;
        end

        assert_set_sticks_R1: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_o[i]);

        assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
            (set_i[i] && clr_i[i]) |=> flag_o[i]);

        assert_clear_takes_R7: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);

        assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
            (!set_i[i] && !clr_i[i]) |=> $stable(flag_o[i]));
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int CW = CODE_W
) (
    input  logic [N-1:0]  pend_i,
    output logic [CW-1:0] code_o
);

    // Scan from the highest index down so the lowest pending index wins.
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i])
                code_o = CW'(i + 1);
        end
    end

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int DW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  flag_i,
    input  vec_code_e     code_i,
    input  logic          rs_full_i,
    input  logic          busy_i,
    input  logic          rx_rd_i,
    input  logic          tx_wr_i,
    output logic [DW-1:0] mask_o,
    output logic [N-1:0]  clr_o,
    output logic [DW-1:0] rdata_o
);

    bus_req_t req;
    logic [N-1:0] clr_w1c, clr_vec, clr_data;

    always_comb begin
        req.wr    = wr_i;
        req.rd    = rd_i;
        req.sel   = decode_ofs(addr_i);
        req.wdata = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_o <= '0;
        else if (req.wr && req.sel == SEL_MASK)
            mask_o <= req.wdata;
    end

    always_comb begin
        clr_w1c = '0;
        if (req.wr && req.sel == SEL_STAT)
            clr_w1c = req.wdata[N-1:0];
    end

    always_comb begin
        clr_vec = '0;
        if (req.rd && req.sel == SEL_VEC && retire_on_read(code_i))
            clr_vec[int'(code_i) - 1] = 1'b1;
    end

    always_comb begin
        clr_data = '0;
        clr_data[EV_RX_IDX] = rx_rd_i;
        clr_data[EV_TX_IDX] = tx_wr_i;
    end

    assign clr_o = clr_w1c | clr_vec | clr_data;

    always_comb begin
        rdata_o = '0;
        case (req.sel)
            SEL_MASK: rdata_o = mask_o;
            SEL_STAT: begin
                rdata_o[N-1:0]          = flag_i;
                rdata_o[STAT_RSFULL_BIT] = rs_full_i;
                rdata_o[STAT_BUSY_BIT]   = busy_i;
            end
            SEL_VEC:  rdata_o[CODE_W-1:0] = code_i;
            default:  rdata_o = '0;
        endcase
    end

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == OFS_MASK) |=> (mask_o == $past(wdata_i)));

    assert_mask_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && addr_i == OFS_MASK) |=> $stable(mask_o));

    assert_vec_read_retires_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == OFS_VEC && code_i inside {VEC_ARB, VEC_NACK, VEC_ARDY, VEC_STOP, VEC_AAS})
        |-> clr_o[int'(code_i) - 1]);

    assert_data_clear_R9: assert property (@(posedge clk) disable iff (rst)
        rx_rd_i |-> clr_o[EV_RX_IDX]);

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int DW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  ev_pulse,
    input  logic          rs_full,
    input  logic          bus_busy,
    input  logic          rx_data_rd,
    input  logic          tx_data_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);

    logic [N-1:0]      flags, clr, pend;
    logic [DW-1:0]     mask;
    logic [CODE_W-1:0] code_raw;
    vec_code_e         code;

    irq_flag_bank #(.N(N)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ev_pulse),
        .clr_i  (clr),
        .flag_o (flags)
    );

    assign pend = flags & mask[N-1:0];

    irq_prio_enc #(.N(N), .CW(CODE_W)) u_enc (
        .pend_i (pend),
        .code_o (code_raw)
    );

    assign code = vec_code_e'(code_raw);

    irq_reg_if #(.N(N), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (reg_addr),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .wdata_i   (reg_wdata),
        .flag_i    (flags),
        .code_i    (code),
        .rs_full_i (rs_full),
        .busy_i    (bus_busy),
        .rx_rd_i   (rx_data_rd),
        .tx_wr_i   (tx_data_wr),
        .mask_o    (mask),
        .clr_o     (clr),
        .rdata_o   (reg_rdata)
    );

    assign irq = |pend;

    assert_irq_vs_vector_R6: assert property (@(posedge clk) disable iff (rst)
        irq == (code != VEC_NONE));

    assert_vector_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        (code != VEC_NONE) |-> (flags[int'(code) - 1] && mask[int'(code) - 1]));

    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (code != VEC_NONE) |->
        ((pend & N'((8'd1 << (int'(code) - 1)) - 8'd1)) == '0));

    assert_reset_clean_R11: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && !irq));

endmodule

// File: tb/test_i2c_irq_unit.sv
module test_i2c_irq_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  ev_pulse = '0;
    logic        rs_full = 1'b0;
    logic        bus_busy = 1'b0;
    logic        rx_data_rd = 1'b0;
    logic        tx_data_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_VEC  = 8'h28;
    localparam logic [7:0] A_GAP  = 8'h0C;

    // {events[26:20], mask[19:4], vector[3:1], irq[0]}
    localparam int NT = 10;
    localparam logic [26:0] TAB [NT] = '{
        {7'h01, 16'h007F, 3'd1, 1'b1},
        {7'h7E, 16'h007F, 3'd2, 1'b1},
        {7'h78, 16'h007F, 3'd4, 1'b1},
        {7'h60, 16'h007F, 3'd6, 1'b1},
        {7'h40, 16'h007F, 3'd7, 1'b1},
        {7'h7F, 16'h0000, 3'd0, 1'b0},
        {7'h7F, 16'h007E, 3'd2, 1'b1},
        {7'h18, 16'h0010, 3'd5, 1'b1},
        {7'h04, 16'h007B, 3'd0, 1'b0},
        {7'h30, 16'h0020, 3'd6, 1'b1}
    };

    localparam logic [2:0] DRAIN [6] = '{3'd1, 3'd2, 3'd3, 3'd6, 3'd7, 3'd0};

    i2c_irq_unit i_i2c_irq_unit (
        .clk        (clk),
        .rst        (rst),
        .ev_pulse   (ev_pulse),
        .rs_full    (rs_full),
        .bus_busy   (bus_busy),
        .rx_data_rd (rx_data_rd),
        .tx_data_wr (tx_data_wr),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [6:0] ev);
        @(negedge clk);
        ev_pulse = ev;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        peek(A_MASK, v); check("R11 mask after reset", v, 16'h0000);
        peek(A_STAT, v); check("R11 status after reset", v, 16'h0000);
        peek(A_VEC, v);  check("R11 vector after reset", v, 16'h0000);
        check("R11 irq after reset", {15'd0, irq}, 16'h0000);

        // R2: full-width mask storage
        bus_write(A_MASK, 16'hBEEF);
        peek(A_MASK, v); check("R2 mask readback", v, 16'hBEEF);

        // Table walk: R1, R3, R4, R5, R6
        for (int t = 0; t < NT; t++) begin
            bus_write(A_MASK, TAB[t][19:4]);
            bus_write(A_STAT, 16'h007F);
            pulse(TAB[t][26:20]);
            peek(A_STAT, v); check("R1/R5 status flags", v, {9'd0, TAB[t][26:20]});
            peek(A_VEC, v);  check("R3/R4 vector code", v, {13'd0, TAB[t][3:1]});
            check("R6 irq level", {15'd0, irq}, {15'd0, TAB[t][0]});
        end

        // R8: drain loop retires non-data events in priority order
        bus_write(A_MASK, 16'h007F);
        bus_write(A_STAT, 16'h007F);
        pulse(7'h67);
        for (int k = 0; k < 6; k++) begin
            bus_read(A_VEC, v);
            check("R8 drain sequence", v, {13'd0, DRAIN[k]});
        end
        check("R8 irq after drain", {15'd0, irq}, 16'h0000);

        // R8/R9: data events survive vector reads, clear from data path
        pulse(7'h18);
        bus_read(A_VEC, v); check("R8 rx code", v, 16'h0004);
        bus_read(A_VEC, v); check("R8 rx not retired by read", v, 16'h0004);
        @(negedge clk); rx_data_rd = 1'b1;
        @(negedge clk); rx_data_rd = 1'b0;
        peek(A_VEC, v); check("R9 rx cleared by data read", v, 16'h0005);
        @(negedge clk); tx_data_wr = 1'b1;
        @(negedge clk); tx_data_wr = 1'b0;
        peek(A_VEC, v); check("R9 tx cleared by data write", v, 16'h0000);

        // R7: write-one-to-clear
        pulse(7'h07);
        bus_write(A_STAT, 16'h0000);
        peek(A_STAT, v); check("R7 zero write keeps flags", v, 16'h0007);
        bus_write(A_STAT, 16'h0002);
        peek(A_STAT, v); check("R7 one clears flag", v, 16'h0005);
        bus_write(A_STAT, 16'h007F);

        // R10: event collides with write-one-to-clear
        @(negedge clk);
        ev_pulse = 7'h20; reg_addr = A_STAT; reg_wdata = 16'h0020; reg_wr = 1'b1;
        @(negedge clk);
        ev_pulse = '0; reg_wr = 1'b0;
        peek(A_STAT, v); check("R10 set beats w1c", v, 16'h0020);
        bus_write(A_STAT, 16'h007F);

        // R10: event collides with retiring vector read
        pulse(7'h01);
        @(negedge clk);
        ev_pulse = 7'h01; reg_addr = A_VEC; reg_rd = 1'b1;
        @(negedge clk);
        ev_pulse = '0; reg_rd = 1'b0;
        peek(A_VEC, v); check("R10 set beats vector read", v, 16'h0001);
        bus_write(A_STAT, 16'h007F);

        // R12: live core bits and dead offsets
        rs_full = 1'b1;
        peek(A_STAT, v); check("R12 rs_full bit 11", v, 16'h0800);
        rs_full = 1'b0; bus_busy = 1'b1;
        peek(A_STAT, v); check("R12 bus_busy bit 12", v, 16'h1000);
        bus_busy = 1'b0;
        bus_write(A_VEC, 16'hFFFF);
        bus_write(A_GAP, 16'hFFFF);
        peek(A_MASK, v); check("R12 mask untouched", v, 16'h007F);
        peek(A_STAT, v); check("R12 status untouched", v, 16'h0000);
        peek(A_GAP, v);  check("R12 unmapped reads zero", v, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule